// File: doc/BRIEF.md
# Hamming SEC-DED word protector

This block guards memory words against bit upsets. On the write side it turns a data word into a stored codeword: the data bits plus Hamming check bits and one overall parity bit. On the read side it takes a codeword back from storage, forms a syndrome, and inverts the one bit the syndrome names. It reports whether a single error was repaired or whether the word holds an error it cannot repair.

Both halves are pure XOR logic. A parameter can add one register stage on every output so the block fits a pipelined read or write path. The storage array, scrubbing and write-back of repaired words belong to the surrounding design.

With the default 32-bit data width there are six Hamming check bits and one overall parity bit, so each codeword is 39 bits wide. The data width is a parameter. The number of Hamming bits is the smallest P with 2^P >= DATA_W + P + 1.

Top module: `secded_guard`

## Requirements
- R1: Codeword bit 0 is the overall parity bit. Bits 1 to N (N = DATA_W + P) are Hamming positions. Positions 1, 2, 4, 8, 16 and 32 hold the check bits. Data bit 0 sits at position 3, and the remaining data bits fill the other positions in ascending order.
- R2: The check bit at position 2^j is the even parity of all data positions whose index has bit j set. The overall bit makes the parity of the whole codeword even.
- R3: Reading back an unaltered codeword returns the original data with both flags low.
- R4: A codeword with exactly one inverted data position returns the original data, with rd_sec high and rd_ded low.
- R5: A codeword with exactly one inverted check bit or overall bit returns the data unchanged, with rd_sec high and rd_ded low.
- R6: A codeword with exactly two inverted bits raises rd_ded with rd_sec low, and returns the data positions as read, uncorrected.
- R7: When overall parity fails and the syndrome points above position N, the word is treated as uncorrectable: rd_ded is high, rd_sec is low and no bit is inverted.
- R8: With REG_OUT = 1, every output follows its inputs one clock later, and a synchronous active-low reset clears all outputs to zero. With REG_OUT = 0, the outputs follow the inputs in the same cycle.
- R9: rd_sec and rd_ded are never high together.
- R10: Correction inverts at most one bit of a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_data | input | DATA_W | Data word to encode |
| wr_code | output | DATA_W+P+1 | Codeword to store |
| rd_code | input | DATA_W+P+1 | Codeword read from storage |
| rd_data | output | DATA_W | Corrected data |
| rd_sec | output | 1 | Single error corrected |
| rd_ded | output | 1 | Uncorrectable error detected |

## Verification
The hardest case to reach is an odd number of errors whose syndrome falls above the last valid position. Single and double flips can never produce it. The bench reaches this case by inverting three chosen check bits whose position indices sum, under XOR, past the end of the code: positions 1, 8 and 32 at 32 bits, and positions 1, 4 and 8 at 8 bits. An 8-bit, unregistered instance is swept over every data value, with every single flip and every pair of flips. The registered 32-bit instance gets many patterns, each with every single flip and a rotating set of pairs.

// File: rtl/secded_pkg.sv
`timescale 1ns/1ps
// Shared helpers for the SEC-DED protector: code sizing, position mapping
// and the read-side status type. Assumes positions are 1-based Hamming indices.
package secded_pkg;

    typedef enum logic [1:0] {
        RD_CLEAN  = 2'd0,
        RD_SINGLE = 2'd1,
        RD_DOUBLE = 2'd2
    } rd_state_e;

    // Smallest number of Hamming bits able to address every position plus "no error".
    function automatic int ham_bits(input int dw);
        int p;
        p = 1;
        while ((1 << p) < dw + p + 1) p++;
        return p;
    endfunction

    // True for positions reserved for check bits.
    function automatic bit is_pow2(input int v);
        return (v > 0) && ((v & (v - 1)) == 0);
    endfunction

    // Data bit index held at a non-power-of-two position.
    function automatic int data_index(input int pos);
        return pos - 1 - $clog2(pos + 1);
    endfunction

endpackage

// File: rtl/secded_enc.sv
`timescale 1ns/1ps
// Write-side encoder: scatters data into Hamming positions, computes even
// check bits with XOR trees and appends the overall parity at bit 0.
// Assumes nothing about timing; purely combinational.
module secded_enc
    import secded_pkg::*;
#(
    parameter  int DATA_W = 32,
    localparam int P      = ham_bits(DATA_W),
    localparam int N_POS  = DATA_W + P,
    localparam int CODE_W = N_POS + 1
) (
    input  logic [DATA_W-1:0] data,
    output logic [CODE_W-1:0] code
);

    logic [N_POS:1] dpos;
    logic [P-1:0]   chk;
    logic [N_POS:1] body;

    // Place data bits at their positions, holes left for check bits.
    for (genvar pos = 1; pos <= N_POS; pos++) begin : g_spread
        if (is_pow2(pos)) begin : g_hole
            assign dpos[pos] = 1'b0;
        end else begin : g_data
            assign dpos[pos] = data[data_index(pos)];
        end
    end

    // Even parity per check bit over positions whose index has that bit set.
    always_comb begin
        chk = '0;
        for (int j = 0; j < P; j++) begin
            for (int pos = 1; pos <= N_POS; pos++) begin
                if (((pos >> j) & 1) == 1) chk[j] = chk[j] ^ dpos[pos];
            end
        end
    end

    // Merge check bits into their slots and append overall parity.
    always_comb begin
        body = dpos;
        for (int j = 0; j < P; j++) body[1 << j] = chk[j];
        code = {body, ^body};
    end

endmodule

// File: rtl/secded_syn.sv
`timescale 1ns/1ps
// Read-side syndrome former: recomputes check bits from the read data
// positions, XORs them with the stored check bits, and tests overall parity.
// Assumes the codeword layout produced by secded_enc.
module secded_syn
    import secded_pkg::*;
#(
    parameter  int DATA_W = 32,
    localparam int P      = ham_bits(DATA_W),
    localparam int N_POS  = DATA_W + P,
    localparam int CODE_W = N_POS + 1
) (
    input  logic [CODE_W-1:0] code,
    output logic [P-1:0]      syn,
    output logic              par_err
);

    logic [P-1:0] recomp;

    // Same parity equations as the encoder, fed from read-back data only.
    always_comb begin
        recomp = '0;
        for (int pos = 1; pos <= N_POS; pos++) begin
            if (!is_pow2(pos)) begin
                for (int j = 0; j < P; j++) begin
                    if (((pos >> j) & 1) == 1) recomp[j] = recomp[j] ^ code[pos];
                end
            end
        end
    end

    // Compare recomputed against stored check bits.
    always_comb begin
        for (int j = 0; j < P; j++) syn[j] = recomp[j] ^ code[1 << j];
    end

    assign par_err = ^code;

endmodule

// File: rtl/secded_fix.sv
`timescale 1ns/1ps
// Read-side corrector: classifies the word, decodes the syndrome to a
// one-hot flip mask and passes each data bit or its complement.
// Assumes syn and par_err come from secded_syn for the same codeword.
module secded_fix
    import secded_pkg::*;
#(
    parameter  int DATA_W = 32,
    localparam int P      = ham_bits(DATA_W),
    localparam int N_POS  = DATA_W + P,
    localparam int CODE_W = N_POS + 1
) (
    input  logic [CODE_W-1:0] code,
    input  logic [P-1:0]      syn,
    input  logic              par_err,
    output logic [DATA_W-1:0] data,
    output logic [N_POS:1]    flip,
    output logic              sec,
    output logic              ded
);

    rd_state_e st;
    logic      in_range;

    assign in_range = (syn != '0) && (int'(syn) <= N_POS);

    // Classify: odd parity means one (repairable) error unless it points off the end.
    always_comb begin
        if (!par_err)
            st = (syn == '0) ? RD_CLEAN : RD_DOUBLE;
        else if ((syn == '0) || in_range)
            st = RD_SINGLE;
        else
            st = RD_DOUBLE;
    end

    // Syndrome decoder and per-bit select between a bit and its inverse.
    for (genvar pos = 1; pos <= N_POS; pos++) begin : g_pos
        localparam logic [P-1:0] SV = P'(pos);
        assign flip[pos] = (st == RD_SINGLE) && (syn == SV);
        if (!is_pow2(pos)) begin : g_data
            assign data[data_index(pos)] = flip[pos] ? ~code[pos] : code[pos];
        end
    end

    assign sec = (st == RD_SINGLE);
    assign ded = (st == RD_DOUBLE);

endmodule

// File: rtl/secded_guard.sv
`timescale 1ns/1ps
// Top of the SEC-DED protector: encoder on the write path, syndrome and
// corrector on the read path, and an optional register stage on all outputs.
// Assumes clk/rst_n are only meaningful when REG_OUT is set.
module secded_guard
    import secded_pkg::*;
#(
    parameter  int DATA_W  = 32,
    parameter  bit REG_OUT = 1'b1,
    localparam int P       = ham_bits(DATA_W),
    localparam int N_POS   = DATA_W + P,
    localparam int CODE_W  = N_POS + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CODE_W-1:0] wr_code,
    input  logic [CODE_W-1:0] rd_code,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_sec,
    output logic              rd_ded
);

    logic [CODE_W-1:0] enc_code;
    logic [P-1:0]      syn;
    logic              par_err;
    logic [DATA_W-1:0] fix_data;
    logic [N_POS:1]    flip_mask;
    logic              fix_sec;
    logic              fix_ded;

    secded_enc #(.DATA_W(DATA_W)) u_enc (
        .data (wr_data),
        .code (enc_code)
    );

    secded_syn #(.DATA_W(DATA_W)) u_syn (
        .code    (rd_code),
        .syn     (syn),
        .par_err (par_err)
    );

    secded_fix #(.DATA_W(DATA_W)) u_fix (
        .code    (rd_code),
        .syn     (syn),
        .par_err (par_err),
        .data    (fix_data),
        .flip    (flip_mask),
        .sec     (fix_sec),
        .ded     (fix_ded)
    );

    if (REG_OUT) begin : g_reg
        // Output stage: one-cycle latency, cleared by synchronous reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                wr_code <= '0;
                rd_data <= '0;
                rd_sec  <= 1'b0;
                rd_ded  <= 1'b0;
            end else begin
                wr_code <= enc_code;
                rd_data <= fix_data;
                rd_sec  <= fix_sec;
                rd_ded  <= fix_ded;
            end
        end
    end else begin : g_comb
        assign wr_code = enc_code;
        assign rd_data = fix_data;
        assign rd_sec  = fix_sec;
        assign rd_ded  = fix_ded;
    end

endmodule

// File: rtl/secded_guard_chk.sv
`timescale 1ns/1ps
// Property checker for secded_guard, attached by bind below.
// Assumes rst_n is held low from time zero until the bench releases it.
module secded_guard_chk
    import secded_pkg::*;
#(
    parameter  int DATA_W  = 32,
    parameter  bit REG_OUT = 1'b1,
    localparam int P       = ham_bits(DATA_W),
    localparam int N_POS   = DATA_W + P,
    localparam int CODE_W  = N_POS + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] wr_data,
    input logic [CODE_W-1:0] wr_code,
    input logic [CODE_W-1:0] rd_code,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_sec,
    input logic              rd_ded,
    input logic [N_POS:1]    flip_mask,
    input logic              fix_ded
);

    logic [1:0] up;

    // Cycles since reset release, saturating; gates history-based checks.
    always_ff @(posedge clk) begin
        if (!rst_n) up <= 2'd0;
        else if (up != 2'd3) up <= up + 2'd1;
    end

    // R9
    sec_ded_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_sec && rd_ded));

    // R2
    code_even_chk: assert property (@(posedge clk) disable iff (!rst_n || up != 2'd3)
        (^wr_code) == 1'b0);

    // R10
    flip_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flip_mask));

    // R7
    ded_no_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fix_ded |-> (flip_mask == '0));

    if (REG_OUT) begin : g_seq
        // R8
        wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || up != 2'd3)
            $stable(wr_data) |=> $stable(wr_code));
        // R8
        rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || up != 2'd3)
            $stable(rd_code) |=> ($stable(rd_data) && $stable(rd_sec) && $stable(rd_ded)));
    end else begin : g_cmb
        // R8
        wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || up != 2'd3)
            $stable(wr_data) |-> $stable(wr_code));
        // R8
        rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || up != 2'd3)
            $stable(rd_code) |-> ($stable(rd_data) && $stable(rd_sec) && $stable(rd_ded)));
    end

endmodule

bind secded_guard secded_guard_chk #(.DATA_W(DATA_W), .REG_OUT(REG_OUT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_data   (wr_data),
    .wr_code   (wr_code),
    .rd_code   (rd_code),
    .rd_data   (rd_data),
    .rd_sec    (rd_sec),
    .rd_ded    (rd_ded),
    .flip_mask (flip_mask),
    .fix_ded   (fix_ded)
);

// File: tb/secded_guard_test.sv
`timescale 1ns/1ps
module secded_guard_test;

    logic clk = 1'b0;
    always #2 clk = ~clk;
    logic rst_n;

    logic [31:0] b_wd;
    logic [38:0] b_rc;
    logic [38:0] b_code;
    logic [31:0] b_data;
    logic        b_sec, b_ded;

    logic [7:0]  s_wd;
    logic [12:0] s_rc;
    logic [12:0] s_code;
    logic [7:0]  s_data;
    logic        s_sec, s_ded;

    secded_guard uut (
        .clk(clk), .rst_n(rst_n), .wr_data(b_wd), .wr_code(b_code),
        .rd_code(b_rc), .rd_data(b_data), .rd_sec(b_sec), .rd_ded(b_ded)
    );

    secded_guard #(.DATA_W(8), .REG_OUT(1'b0)) u_small (
        .clk(clk), .rst_n(rst_n), .wr_data(s_wd), .wr_code(s_code),
        .rd_code(s_rc), .rd_data(s_data), .rd_sec(s_sec), .rd_ded(s_ded)
    );

    int checks = 0;
    int errors = 0;

    task automatic check_eq(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int m_np(input int dw);
        int p = 1;
        while ((1 << p) < dw + p + 1) p++;
        return p;
    endfunction

    function automatic bit m_hole(input int v);
        return (v & (v - 1)) == 0;
    endfunction

    // Reference encoder built from R1 and R2.
    function automatic logic [63:0] m_encode(input logic [31:0] d, input int dw);
        logic [63:0] c = '0;
        int np = m_np(dw);
        int k = 0;
        for (int pos = 1; pos <= dw + np; pos++) begin
            if (!m_hole(pos)) begin
                c[pos] = d[k];
                k++;
            end
        end
        for (int j = 0; j < np; j++) begin
            logic p = 1'b0;
            for (int pos = 1; pos <= dw + np; pos++)
                if (!m_hole(pos) && ((pos >> j) & 1) == 1) p = p ^ c[pos];
            c[1 << j] = p;
        end
        c[0] = ^c;
        return c;
    endfunction

    // Data positions read straight out of a codeword, no correction.
    function automatic logic [31:0] m_raw(input logic [63:0] c, input int dw);
        logic [31:0] d = '0;
        int k = 0;
        for (int pos = 1; pos <= dw + m_np(dw); pos++) begin
            if (!m_hole(pos)) begin
                d[k] = c[pos];
                k++;
            end
        end
        return d;
    endfunction

    task automatic big_apply(input logic [31:0] d, input logic [38:0] rc);
        @(negedge clk);
        b_wd = d;
        b_rc = rc;
        @(negedge clk);
        #1;
    endtask

    task automatic small_apply(input logic [7:0] d, input logic [12:0] rc);
        @(negedge clk);
        s_wd = d;
        s_rc = rc;
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [38:0] c;
        logic [38:0] rc;
        rst_n = 1'b0;
        b_wd  = 32'hDEAD_BEEF;
        b_rc  = '1;
        s_wd  = '0;
        s_rc  = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8: registered outputs cleared while reset is low
        check_eq("R8 reset state", {b_code, b_data, b_sec, b_ded}, 64'd0);
        rst_n = 1'b1;

        // R8: one-cycle latency on the registered instance
        c = m_encode(32'h1234_5678, 32);
        big_apply(32'h1234_5678, c);
        @(negedge clk);
        d = 32'hA5A5_0F0F;
        b_wd = d;
        b_rc = m_encode(d, 32);
        #1;
        check_eq("R8 old value held before edge", {b_data, b_sec, b_ded}, {32'h1234_5678, 2'b00});
        @(negedge clk);
        #1;
        check_eq("R8 new value after edge", {b_data, b_sec, b_ded}, {d, 2'b00});

        for (int w = 0; w < 24; w++) begin
            if (w == 0) d = 32'h0;
            else if (w == 1) d = 32'hFFFF_FFFF;
            else d = (w * 32'h9E37_79B9) ^ (w << 7);
            c = m_encode(d, 32);
            big_apply(d, c);
            check_eq("R1 R2 encode", b_code, c);
            check_eq("R3 clean read", {b_data, b_sec, b_ded}, {d, 2'b00});
            for (int b = 0; b < 39; b++) begin
                rc = c ^ (39'd1 << b);
                big_apply(d, rc);
                if (b == 0 || m_hole(b)) begin
                    check_eq("R5 check-bit flip", {b_data, b_sec, b_ded}, {d, 2'b10});
                end else begin
                    check_eq("R4 R9 data flip", {b_data, b_sec, b_ded}, {d, 2'b10});
                    check_eq("R10 one bit repaired", $countones(b_data ^ m_raw(rc, 32)), 1);
                end
            end
            for (int b = 0; b < 39; b += 3) begin
                int b2 = (b + 5 + w) % 39;
                if (b2 != b) begin
                    rc = c ^ (39'd1 << b) ^ (39'd1 << b2);
                    big_apply(d, rc);
                    check_eq("R6 double flip", {b_data, b_sec, b_ded}, {m_raw(rc, 32), 2'b01});
                end
            end
        end

        // R7: flips at positions 1, 8, 32 give syndrome 41 (> 38) with odd parity
        c  = m_encode(32'hCAFE_0001, 32);
        rc = c ^ (39'd1 << 1) ^ (39'd1 << 8) ^ (39'd1 << 32);
        big_apply(32'hCAFE_0001, rc);
        check_eq("R7 off-range syndrome", {b_data, b_sec, b_ded}, {m_raw(rc, 32), 2'b01});

        // Exhaustive sweep of the 8-bit combinational instance
        for (int v = 0; v < 256; v++) begin
            logic [12:0] sc;
            sc = m_encode(32'(v), 8);
            small_apply(8'(v), sc);
            check_eq("R1 R2 R8 small encode", s_code, sc);
            check_eq("R3 small clean", {s_data, s_sec, s_ded}, {8'(v), 2'b00});
            for (int b = 0; b < 13; b++) begin
                small_apply(8'(v), sc ^ (13'd1 << b));
                if (b == 0 || m_hole(b))
                    check_eq("R5 small check flip", {s_data, s_sec, s_ded}, {8'(v), 2'b10});
                else
                    check_eq("R4 small data flip", {s_data, s_sec, s_ded}, {8'(v), 2'b10});
            end
            for (int b1 = 0; b1 < 13; b1++) begin
                for (int b2 = b1 + 1; b2 < 13; b2++) begin
                    logic [12:0] r2;
                    r2 = sc ^ (13'd1 << b1) ^ (13'd1 << b2);
                    small_apply(8'(v), r2);
                    check_eq("R6 small double", {s_data, s_sec, s_ded},
                             {m_raw(64'(r2), 8)[7:0], 2'b01});
                end
            end
            // R7: positions 1, 4, 8 give syndrome 13 (> 12) with odd parity
            small_apply(8'(v), sc ^ 13'b0_0001_0001_0010);
            check_eq("R7 small off-range", {s_data, s_sec, s_ded},
                     {m_raw(64'(sc ^ 13'b0_0001_0001_0010), 8)[7:0], 2'b01});
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule